// File: doc/BRIEF.md
# Readback Trailer Integrity Monitor

This block sits beside a serial configuration-readback path. The readback stream repeats frame after frame. Each frame is a fixed number of valid bits, and the last few of them carry a checksum word produced by the device. A position counter steps only on valid bits and locates that trailer. The trailer bits are shifted into a capture register, most significant bit first. When the last trailer bit arrives, the captured word is compared with a reference word held outside the block. One cycle later the block reports the verdict and re-arms by itself for the next frame, so the configuration is checked continuously with no software involvement.

A start-of-frame pulse aligns the counter. If a frame is cut short by an early start-of-frame, the block reports a framing error for that frame instead of a verdict. A sticky error bit collects every mismatch until it is cleared. A saturating counter records how many frames have been checked. The block only compares the checksum: it does not produce the readback stream and does not compute any checksum.

Top module: `crc_trailer_monitor`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, check_done, mismatch, framing_err and sticky_err are 0 and frame_count is 0.
- R2: A frame is FRAME_BITS valid bits long, and its last CRC_W valid bits form the trailer, with the first trailer bit as bit CRC_W-1 (most significant bit first). check_done is high for exactly one cycle, the cycle after the last trailer bit is accepted. In that cycle mismatch is 1 when the captured word differs from ref_crc and 0 when it matches. mismatch then keeps that value until the next check.
- R3: A frame_start in a cycle where the bit position is not 0 (the frame is part-way through) makes framing_err high for one cycle, in the next cycle. No check is made for the cut frame. The bit that comes with that frame_start becomes bit 0 of a new frame.
- R4: The bit position advances only on cycles with bit_valid high. Cycles with bit_valid low, and all bits that arrive before the first frame_start after reset, have no effect on any output.
- R5: sticky_err is set by a check that finds a mismatch. It stays set until err_clear is high or reset. When a mismatching check and err_clear happen in the same cycle, the bit ends up set.
- R6: frame_count rises by one with every check, whether it passes or fails. It stops at 2^CNT_W-1. A cut frame does not count.
- R7: After the last bit of a frame the position returns to 0, so frames that follow back to back without a frame_start are each checked.
- R8: ref_crc is sampled in the cycle that carries the last trailer bit. Changes to it at other times do not alter mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Serial readback data |
| bit_valid | input | 1 | bit_in carries a bit this cycle |
| frame_start | input | 1 | Marks the first bit of a frame; realigns the position |
| ref_crc | input | CRC_W | Expected trailer word |
| err_clear | input | 1 | Clears the sticky error |
| check_done | output | 1 | One-cycle pulse when a verdict is made |
| mismatch | output | 1 | Result of the latest check; 1 means the words differ |
| framing_err | output | 1 | One-cycle pulse when a frame was cut short |
| sticky_err | output | 1 | Accumulated mismatch flag |
| frame_count | output | CNT_W | Saturating count of checks made |

## Verification
The hardest states to reach are a frame_start that lands exactly on a frame's final bit, and an err_clear that coincides with a failing verdict. In both cases the outcome depends on a single cycle lining up. The bench builds frames bit by bit, so it can place frame_start, err_clear and ref_crc changes on any chosen bit index, with idle gaps in between. A small frame counter width lets saturation be reached in a few frames, and a behavioural model driven by bit queues predicts every output on every cycle.

// File: rtl/rtm_pkg.sv
package rtm_pkg;

   // per-cycle position decode shared between tracker and the rest
   typedef struct packed {
      logic take;        // bit accepted into the current frame
      logic at_last;     // accepted bit is the frame's final bit
      logic in_trailer;  // current position lies inside the trailer
      logic cut;         // frame_start arrived mid-frame
   } pos_info_t;

   function automatic int unsigned pos_width(input int unsigned nbits);
      return (nbits < 2) ? 1 : $clog2(nbits);
   endfunction

endpackage

// File: rtl/rtm_pos_tracker.sv
module rtm_pos_tracker
   import rtm_pkg::*;
#(
   parameter int unsigned FRAME_BITS = 64,
   parameter int unsigned CRC_W      = 16
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      frame_start,
   input  logic      bit_valid,
   output pos_info_t info
);
   localparam int unsigned POS_W = pos_width(FRAME_BITS);
   localparam logic [POS_W-1:0] LAST_POS  = POS_W'(FRAME_BITS - 1);
   localparam logic [POS_W-1:0] TRAIL_POS = POS_W'(FRAME_BITS - CRC_W);

   logic [POS_W-1:0] pos_q;
   logic [POS_W-1:0] pos_eff;
   logic             locked_q;

   always_comb begin
      pos_eff         = frame_start ? '0 : pos_q;
      info.take       = bit_valid & (locked_q | frame_start);
      info.at_last    = info.take & (pos_eff == LAST_POS);
      info.in_trailer = (pos_eff >= TRAIL_POS);
      info.cut        = frame_start & locked_q & (pos_q != '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q    <= '0;
         locked_q <= 1'b0;
      end else begin
         if (frame_start)
            locked_q <= 1'b1;
         if (info.take)
            pos_q <= info.at_last ? '0 : pos_eff + POS_W'(1);
         else if (frame_start)
            pos_q <= '0;
      end
   end
endmodule

// File: rtl/rtm_trailer_capture.sv
module rtm_trailer_capture #(
   parameter int unsigned CRC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             bit_in,
   output logic [CRC_W-1:0] word_now
);
   // holds the trailer bits seen so far; the live bit completes the word
   logic [CRC_W-2:0] hist_q;

   assign word_now = {hist_q, bit_in};

   always_ff @(posedge clk) begin
      if (!rst_n)
         hist_q <= '0;
      else if (shift_en)
         hist_q <= word_now[CRC_W-2:0];
   end
endmodule

// File: rtl/rtm_verdict.sv
module rtm_verdict #(
   parameter int unsigned CRC_W = 16,
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             at_last,
   input  logic             cut,
   input  logic [CRC_W-1:0] word_now,
   input  logic [CRC_W-1:0] ref_crc,
   input  logic             err_clear,
   output logic             check_done,
   output logic             mismatch,
   output logic             framing_err,
   output logic             sticky_err,
   output logic [CNT_W-1:0] frame_count
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic differs;
   assign differs = (word_now != ref_crc);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         check_done  <= 1'b0;
         mismatch    <= 1'b0;
         framing_err <= 1'b0;
         sticky_err  <= 1'b0;
         frame_count <= '0;
      end else begin
         check_done  <= at_last;
         framing_err <= cut;
         if (at_last)
            mismatch <= differs;
         sticky_err <= (at_last & differs) | (sticky_err & ~err_clear);
         if (at_last && frame_count != CNT_MAX)
            frame_count <= frame_count + CNT_W'(1);
      end
   end
endmodule

// File: rtl/crc_trailer_monitor.sv
module crc_trailer_monitor
   import rtm_pkg::*;
#(
   parameter int unsigned FRAME_BITS = 64,
   parameter int unsigned CRC_W      = 16,
   parameter int unsigned CNT_W      = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_in,
   input  logic             bit_valid,
   input  logic             frame_start,
   input  logic [CRC_W-1:0] ref_crc,
   input  logic             err_clear,
   output logic             check_done,
   output logic             mismatch,
   output logic             framing_err,
   output logic             sticky_err,
   output logic [CNT_W-1:0] frame_count
);
   generate
      if (CRC_W < 2) begin : g_bad_crc_w
         $error("crc_trailer_monitor: CRC_W must be at least 2");
      end
      if (FRAME_BITS <= CRC_W + 1) begin : g_bad_frame
         $error("crc_trailer_monitor: FRAME_BITS must exceed CRC_W by at least 2");
      end
      if (CNT_W < 1) begin : g_bad_cnt_w
         $error("crc_trailer_monitor: CNT_W must be at least 1");
      end
   endgenerate

   pos_info_t        info;
   logic [CRC_W-1:0] word_now;

   rtm_pos_tracker #(.FRAME_BITS(FRAME_BITS), .CRC_W(CRC_W)) u_pos (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .bit_valid   (bit_valid),
      .info        (info)
   );

   rtm_trailer_capture #(.CRC_W(CRC_W)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (info.take & info.in_trailer),
      .bit_in   (bit_in),
      .word_now (word_now)
   );

   rtm_verdict #(.CRC_W(CRC_W), .CNT_W(CNT_W)) u_verdict (
      .clk         (clk),
      .rst_n       (rst_n),
      .at_last     (info.at_last),
      .cut         (info.cut),
      .word_now    (word_now),
      .ref_crc     (ref_crc),
      .err_clear   (err_clear),
      .check_done  (check_done),
      .mismatch    (mismatch),
      .framing_err (framing_err),
      .sticky_err  (sticky_err),
      .frame_count (frame_count)
   );
endmodule

// File: rtl/rtm_checker.sv
module rtm_checker #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             err_clear,
   input logic             check_done,
   input logic             mismatch,
   input logic             framing_err,
   input logic             sticky_err,
   input logic [CNT_W-1:0] frame_count
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      check_done |=> !check_done);

   p_mismatch_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !check_done |-> $stable(mismatch));

   p_cut_no_verdict_r3: assert property (@(posedge clk) disable iff (!rst_n)
      framing_err |-> !check_done);

   p_sticky_on_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (check_done && mismatch) |-> sticky_err);

   p_sticky_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky_err && !err_clear) |=> sticky_err);

   p_count_steps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (check_done && $past(frame_count) != CNT_MAX) |-> frame_count == $past(frame_count) + CNT_W'(1));

   p_count_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !check_done |-> $stable(frame_count));
endmodule

bind crc_trailer_monitor rtm_checker #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .err_clear   (err_clear),
   .check_done  (check_done),
   .mismatch    (mismatch),
   .framing_err (framing_err),
   .sticky_err  (sticky_err),
   .frame_count (frame_count)
);

// File: tb/crc_trailer_monitor_tb.sv
module crc_trailer_monitor_tb;
   localparam int FB    = 24;
   localparam int CW    = 8;
   localparam int NW    = 3;
   localparam int NMAX  = (1 << NW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bit_in = 1'b0, bit_valid = 1'b0, frame_start = 1'b0, err_clear = 1'b0;
   logic [CW-1:0] ref_crc = 8'hA5;
   logic          check_done, mismatch, framing_err, sticky_err;
   logic [NW-1:0] frame_count;

   always #5 clk = ~clk;

   crc_trailer_monitor #(.FRAME_BITS(FB), .CRC_W(CW), .CNT_W(NW)) u_dut (
      .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_valid(bit_valid),
      .frame_start(frame_start), .ref_crc(ref_crc), .err_clear(err_clear),
      .check_done(check_done), .mismatch(mismatch), .framing_err(framing_err),
      .sticky_err(sticky_err), .frame_count(frame_count)
   );

   int    n_checks = 0, n_fail = 0;
   string cur_req = "R1";

   // behavioural model
   bit locked = 0;
   bit frame_q[$];
   bit e_done = 0, e_mis = 0, e_ferr = 0, e_sticky = 0;
   int e_cnt = 0;

   task automatic model_step(input bit sof, input bit v, input bit b, input bit clr,
                             input logic [CW-1:0] refw);
      logic [CW-1:0] w;
      e_done = 0; e_ferr = 0;
      if (clr) e_sticky = 0;
      if (sof && locked && frame_q.size() != 0) e_ferr = 1;
      if (sof) begin frame_q.delete(); locked = 1; end
      if (v && locked) begin
         frame_q.push_back(b);
         if (frame_q.size() == FB) begin
            for (int i = 0; i < CW; i++) w[CW-1-i] = frame_q[FB-CW+i];
            e_done = 1;
            e_mis  = (w != refw);
            if (e_mis) e_sticky = 1;
            if (e_cnt < NMAX) e_cnt++;
            frame_q.delete();
         end
      end
   endtask

   task automatic compare();
      n_checks++;
      if (check_done !== e_done || mismatch !== e_mis || framing_err !== e_ferr ||
          sticky_err !== e_sticky || frame_count !== NW'(e_cnt)) begin
         n_fail++;
         $display("FAIL %s: got done=%0b mis=%0b ferr=%0b sticky=%0b cnt=%0d exp done=%0b mis=%0b ferr=%0b sticky=%0b cnt=%0d",
                  cur_req, check_done, mismatch, framing_err, sticky_err, frame_count,
                  e_done, e_mis, e_ferr, e_sticky, e_cnt);
      end
   endtask

   task automatic step(input bit sof, input bit v, input bit b);
      frame_start = sof; bit_valid = v; bit_in = b;
      @(posedge clk);
      model_step(sof, v, b, err_clear, ref_crc);
      @(negedge clk);
      compare();
   endtask

   // one frame; trailer = crc MSB first; optional idle gaps; optional clear on last bit
   task automatic send_frame(input logic [CW-1:0] crc, input int seed, input int gap,
                             input bit sof, input bit clr_last);
      for (int i = 0; i < FB; i++) begin
         bit b;
         if (i < FB - CW) b = ((i * 5 + seed) % 3) == 0;
         else             b = crc[CW-1-(i-(FB-CW))];
         if (gap > 0 && (i % gap) == gap - 1) step(0, 0, 0);
         err_clear = clr_last && (i == FB - 1);
         step(sof && i == 0, 1, b);
      end
      err_clear = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state during and just after reset
      repeat (3) @(posedge clk);
      @(negedge clk); cur_req = "R1"; compare();
      rst_n = 1;
      step(0, 0, 0);

      // R4: bits before any frame_start are ignored
      cur_req = "R4";
      for (int i = 0; i < 2 * FB; i++) step(0, 1, i[0]);

      // R2: matching frame, then mismatching frame
      cur_req = "R2";
      send_frame(8'hA5, 1, 0, 1, 0);
      send_frame(8'h3C, 2, 0, 1, 0);
      // R4: gaps of invalid cycles inside a frame
      cur_req = "R4";
      send_frame(8'hA5, 3, 4, 1, 0);

      // R5: clear alone, then clear colliding with a failing check
      cur_req = "R5";
      err_clear = 1; step(0, 0, 0); err_clear = 0; step(0, 0, 0);
      send_frame(8'h01, 4, 0, 1, 1);
      step(0, 0, 0);

      // R3: frame cut mid-way, and cut on the final bit
      cur_req = "R3";
      step(1, 1, 1);
      for (int i = 0; i < 9; i++) step(0, 1, i[1]);
      send_frame(8'hA5, 5, 0, 1, 0);
      step(1, 1, 0);
      for (int i = 1; i < FB - 1; i++) step(0, 1, 0);
      step(1, 1, 1);
      step(0, 0, 0);
      frame_start = 0;

      // R7: back-to-back frames without frame_start
      cur_req = "R7";
      for (int i = 1; i < FB; i++) step(0, 1, 0); // finish frame begun above
      send_frame(8'hA5, 6, 0, 0, 0);
      send_frame(8'h5A, 7, 3, 0, 0);

      // R8: ref change outside the last-bit cycle does not affect mismatch
      cur_req = "R8";
      send_frame(8'hA5, 8, 0, 1, 0);
      ref_crc = 8'hFF; step(0, 0, 0); step(0, 0, 0);
      send_frame(8'hFF, 9, 0, 1, 0);
      ref_crc = 8'h00; step(0, 0, 0);

      // R6: run count into saturation
      cur_req = "R6";
      for (int k = 0; k < NMAX + 2; k++) send_frame(8'h00, k, 0, 1, 0);
      step(0, 0, 0);

      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule